// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block is the column-side burst sequencer of a four-bank, 16-bit synchronous DRAM. It receives already-decoded commands with a bank and a column address. It keeps the programmed mode word, which sets the burst length, the burst order and the read latency. For each burst it emits one column address per clock. Read beats come back as a data-valid strobe that carries its column and bank and is delayed by the programmed latency. Write beats produce a write enable with byte enables in the same cycle as the column.

The engine does not store data. Whatever memory sits behind it uses `col_o`/`bank_o` with `wr_en_o`/`wr_be_o` to write. It uses `rd_col_o`/`rd_bank_o` with `rd_valid_o`/`rd_mask_o` to return read data with the blanked bytes removed. The engine handles bursts cut short by a terminate command and bursts replaced by a new read or write on any cycle, whether even or odd. It also handles a full-page mode that wraps around the 512-column page until it is stopped.

Top module: `sdram_burst_engine`

## Requirements
- R1: `cmd_i` encodes 0 = no-op, 1 = mode load, 2 = read, 3 = write, 4 = terminate, and any other code acts as a no-op. All inputs are sampled on the rising clock edge and every output is registered. After reset no strobe is active and the mode is burst length 1, sequential order, read latency 2.
- R2: A mode load takes `mode_i` as {latency[6:4], order[3], length[2:0]}. Length codes are 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page. Order 0 is sequential and 1 is interleaved. Latency codes are 010 = 2 and 011 = 3. If any field holds another code, the whole word is discarded, the old mode stays, and `mode_err_o` is high for the single cycle after the load.
- R3: A load that combines interleaved order with full-page length is rejected and flagged in the same way as R2.
- R4: The column for beat k of a sequential burst of length L that starts at column s is (s with its low log2(L) bits cleared) OR ((s+k) mod L). Beat 0 appears on `col_o` with `col_valid_o` in the cycle after the command, and one beat follows per cycle until L beats have been issued.
- R5: In interleaved order, the low log2(L) bits of beat k are those of s XOR k. The upper bits stay those of s.
- R6: A full-page burst issues column (s+k) mod 512 on every cycle, without end, until a terminate, a mode load or a new read or write arrives.
- R7: For a read command sampled in cycle n with latency CL, read beat k asserts `rd_valid_o` in cycle n+CL+k. `rd_col_o` and `rd_bank_o` equal that beat's column and bank.
- R8: A write beat asserts `wr_en_o` in the same cycle as its column. `wr_be_o` is the inverse of `dqm_i` sampled with that beat (bit 1 = upper byte, bit 0 = lower byte).
- R9: `rd_mask_o` equals the `dqm_i` value presented two cycles earlier. A set bit blanks that byte of the read word returned in that cycle.
- R10: After a terminate, no further column beat is issued. Read beats whose column was already issued still deliver their strobe.
- R11: A read or write arriving during any cycle of a burst replaces that burst. The next cycle carries beat 0 of the new command at its own column and bank.
- R12: `bank_o` and `rd_bank_o` carry, on every beat, the bank given with the command that started the burst.
- R13: A mode load ends any burst in progress. No column beat follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Target bank of a read or write |
| col_i | input | 9 | Start column of a read or write |
| mode_i | input | 7 | Mode word taken on a mode load |
| dqm_i | input | 2 | Byte masks, bit 1 upper, bit 0 lower |
| col_valid_o | output | 1 | A column beat is issued this cycle |
| col_o | output | 9 | Column of the current beat |
| bank_o | output | 2 | Bank of the current beat |
| wr_en_o | output | 1 | Current beat is a write |
| wr_be_o | output | 2 | Byte enables of the write beat |
| rd_valid_o | output | 1 | Read data for a beat is due this cycle |
| rd_col_o | output | 9 | Column of the due read beat |
| rd_bank_o | output | 2 | Bank of the due read beat |
| rd_mask_o | output | 2 | Bytes to blank in the returned read word |
| mode_err_o | output | 1 | Previous mode load was rejected |

## Verification
The latency check assumes that no mode load arrives while read beats are still in the delay pipeline, because changing the latency moves the tap under beats already in flight. The bench keeps to this by letting each burst drain fully before it loads a new mode. The only mode loads it issues during a burst are the ones aimed at R13, and those are issued while the burst is a write. The mask-delay and byte-enable checks take `dqm_i` as driven on every cycle. The bench therefore drives it away from the clock edge and holds it at zero outside the masked-data section.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int MODE_W   = 7;
  localparam int MASK_LAT = 2;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_LMR  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_TERM = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [2:0] cl_code;
    logic       il;
    logic [2:0] bl_code;
  } mode_t;

  function automatic logic mode_ok(input mode_t m);
    logic bl_ok, cl_ok;
    bl_ok = (m.bl_code[2] == 1'b0) || (m.bl_code == 3'b111);
    cl_ok = (m.cl_code == 3'b010) || (m.cl_code == 3'b011);
    return bl_ok && cl_ok && !(m.il && m.bl_code == 3'b111);
  endfunction
endpackage

// File: rtl/sdb_mode_reg.sv
module sdb_mode_reg
  import sdb_pkg::*;
#(
  parameter int               COL_W    = 9,
  parameter logic [MODE_W-1:0] RST_MODE = 7'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]  lowm_o,
  output logic              page_o,
  output logic              il_o,
  output logic              cl3_o,
  output logic              err_o
);
  mode_t mode_q, mode_in;
  logic  err_q;

  assign mode_in = mode_t'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_t'(RST_MODE);
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (load_i) begin
        if (mode_ok(mode_in)) mode_q <= mode_in;
        else                  err_q  <= 1'b1;
      end
    end
  end

  assign page_o = (mode_q.bl_code == 3'b111);
  assign il_o   = mode_q.il;
  assign cl3_o  = (mode_q.cl_code == 3'b011);
  assign err_o  = err_q;

  always_comb begin
    if (page_o) lowm_o = '1;
    else        lowm_o = COL_W'((32'd1 << mode_q.bl_code[1:0]) - 32'd1);
  end

  a_r2_err_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(load_i));
  a_r2_bad_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !mode_ok(mode_in)) |=> $stable(mode_q));
  a_r3_no_il_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(il_o && page_o));
endmodule

// File: rtl/sdb_col_gen.sv
module sdb_col_gen
  import sdb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  lowm_i,
  input  logic              page_i,
  input  logic              il_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              rd_o
);
  logic              act_q, page_q, il_q, rd_q, vld_q;
  logic [COL_W-1:0]  st_q, cnt_q, lowm_q, col_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  off, nxt_col;
  logic              last, is_burst;

  assign is_burst = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);

  always_comb begin
    off     = il_q ? (st_q ^ cnt_q) : (st_q + cnt_q);
    nxt_col = (st_q & ~lowm_q) | (off & lowm_q);
    last    = !page_q && (cnt_q == lowm_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
      il_q   <= 1'b0;
      rd_q   <= 1'b0;
      vld_q  <= 1'b0;
      st_q   <= '0;
      cnt_q  <= '0;
      lowm_q <= '0;
      col_q  <= '0;
      bank_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (is_burst) begin
        vld_q  <= 1'b1;
        col_q  <= col_i;
        bank_q <= bank_i;
        rd_q   <= (cmd_i == CMD_RD);
        st_q   <= col_i;
        cnt_q  <= COL_W'(1);
        lowm_q <= lowm_i;
        page_q <= page_i;
        il_q   <= il_i;
        act_q  <= page_i || (lowm_i != '0);
      end else if (cmd_i == CMD_TERM || cmd_i == CMD_LMR) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        vld_q <= 1'b1;
        col_q <= nxt_col;
        cnt_q <= cnt_q + COL_W'(1);
        if (last) act_q <= 1'b0;
      end
    end
  end

  assign col_valid_o = vld_q;
  assign col_o       = col_q;
  assign bank_o      = bank_q;
  assign rd_o        = rd_q;

  a_r6_page_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && page_q && cmd_i == CMD_NOP) |=> col_valid_o);
  a_r4_count_in_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !page_q) |-> (cnt_q <= lowm_q));
  a_r12_bank_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !is_burst) |=> $stable(bank_o));
endmodule

// File: rtl/sdb_rd_pipe.sv
module sdb_rd_pipe
  import sdb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              cl3_i,
  input  logic [1:0]        dqm_i,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic [1:0]        rd_mask_o
);
  localparam int DEPTH = MAX_CL - 1;
  localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  v_q;
  logic [COL_W-1:0]  c_q [DEPTH];
  logic [BANK_W-1:0] b_q [DEPTH];
  logic [1:0]        m_q [MASK_LAT];
  logic [TAP_W-1:0]  tap;
  logic [1:0]        warm_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          c_q[0] <= '0;
          b_q[0] <= '0;
        end else begin
          v_q[0] <= beat_i;
          c_q[0] <= col_i;
          b_q[0] <= bank_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          c_q[i] <= '0;
          b_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          c_q[i] <= c_q[i-1];
          b_q[i] <= b_q[i-1];
        end
      end
    end
  end

  for (genvar j = 0; j < MASK_LAT; j++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     m_q[j] <= '0;
      else if (j == 0) m_q[j] <= dqm_i;
      else             m_q[j] <= m_q[(j == 0) ? 0 : j-1];
    end
  end

  // latency code 2 reads stage 0, code 3 reads stage 1
  assign tap        = TAP_W'(cl3_i);
  assign rd_valid_o = v_q[tap];
  assign rd_col_o   = c_q[tap];
  assign rd_bank_o  = b_q[tap];
  assign rd_mask_o  = m_q[MASK_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != 2'd2)    warm_q <= warm_q + 2'd1;
  end

  a_r9_mask_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (rd_mask_o == $past(dqm_i, MASK_LAT)));
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdb_pkg::*;
#(
  parameter int               COL_W    = 9,
  parameter int               BANK_W   = 2,
  parameter int               MAX_CL   = 3,
  parameter logic [MODE_W-1:0] RST_MODE = 7'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        dqm_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              wr_en_o,
  output logic [1:0]        wr_be_o,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic [1:0]        rd_mask_o,
  output logic              mode_err_o
);
  logic [COL_W-1:0] lowm;
  logic             page, il, cl3, col_rd;
  logic [1:0]       be_q;

  sdb_mode_reg #(.COL_W(COL_W), .RST_MODE(RST_MODE)) i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd_i == CMD_LMR),
    .mode_i (mode_i),
    .lowm_o (lowm),
    .page_o (page),
    .il_o   (il),
    .cl3_o  (cl3),
    .err_o  (mode_err_o)
  );

  sdb_col_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) i_col (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .lowm_i      (lowm),
    .page_i      (page),
    .il_i        (il),
    .col_valid_o (col_valid_o),
    .col_o       (col_o),
    .bank_o      (bank_o),
    .rd_o        (col_rd)
  );

  sdb_rd_pipe #(.COL_W(COL_W), .BANK_W(BANK_W), .MAX_CL(MAX_CL)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (col_valid_o && col_rd),
    .col_i      (col_o),
    .bank_i     (bank_o),
    .cl3_i      (cl3),
    .dqm_i      (dqm_i),
    .rd_valid_o (rd_valid_o),
    .rd_col_o   (rd_col_o),
    .rd_bank_o  (rd_bank_o),
    .rd_mask_o  (rd_mask_o)
  );

  // write masks act on the beat sampled in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) be_q <= '0;
    else         be_q <= ~dqm_i;
  end

  assign wr_en_o = col_valid_o && !col_rd;
  assign wr_be_o = be_q;

  a_r11_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD || cmd_i == CMD_WR) |=>
      (col_valid_o && col_o == $past(col_i) && bank_o == $past(bank_i)));
  a_r10_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_TERM) |=> !col_valid_o);
  a_r13_load_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_LMR) |=> !col_valid_o);
  a_r8_write_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_be_o == ~$past(dqm_i)));
  a_r7_cl2_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_rd && !cl3 && cmd_i != CMD_LMR) |=>
      (rd_valid_o && rd_col_o == $past(col_o) && rd_bank_o == $past(bank_o)));
endmodule

// File: tb/test_sdram_burst_engine.sv
module test_sdram_burst_engine;
  import sdb_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_i = CMD_NOP;
  logic [1:0] bank_i = '0;
  logic [8:0] col_i = '0;
  logic [6:0] mode_i = '0;
  logic [1:0] dqm_i = '0;
  logic       col_valid_o, wr_en_o, rd_valid_o, mode_err_o;
  logic [8:0] col_o, rd_col_o;
  logic [1:0] bank_o, rd_bank_o, wr_be_o, rd_mask_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic [15:0] mem [4][64];

  sdram_burst_engine i_sdram_burst_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
    .mode_i(mode_i), .dqm_i(dqm_i), .col_valid_o(col_valid_o), .col_o(col_o),
    .bank_o(bank_o), .wr_en_o(wr_en_o), .wr_be_o(wr_be_o), .rd_valid_o(rd_valid_o),
    .rd_col_o(rd_col_o), .rd_bank_o(rd_bank_o), .rd_mask_o(rd_mask_o),
    .mode_err_o(mode_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wd(input int b, input int c);
    return 16'h5A00 ^ 16'(b << 9) ^ 16'(c);
  endfunction

  function automatic int exp_col(input int st, input int k, input int bl, input bit il);
    int m = bl - 1;
    return ((st & ~m) | ((il ? (st ^ k) : (st + k)) & m)) & 511;
  endfunction

  // behavioural array written from the write strobes
  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      if (wr_be_o[0]) mem[bank_o][col_o[5:0]][7:0]  = wd(bank_o, col_o)[7:0];
      if (wr_be_o[1]) mem[bank_o][col_o[5:0]][15:8] = wd(bank_o, col_o)[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] c, input int b, input int col);
    cmd_i  = c;
    bank_i = 2'(b);
    col_i  = 9'(col);
  endtask

  task automatic set_mode(input logic [6:0] code, input bit exp_err, input string req);
    step();
    cmd_i  = CMD_LMR;
    mode_i = code;
    step();
    cmd_i = CMD_NOP;
    chk(mode_err_o == exp_err, req, mode_err_o, exp_err);
  endtask

  task automatic run_read(input int b, input int st, input int bl, input bit il,
                          input int cl, input string req);
    step();
    drive(CMD_RD, b, st);
    for (int s = 1; s <= bl + cl; s++) begin
      step();
      cmd_i = CMD_NOP;
      if (s - 1 < bl)
        chk(col_valid_o && col_o == exp_col(st, s-1, bl, il) && bank_o == 2'(b),
            {req, " col"}, {col_valid_o, 2'b0, col_o}, exp_col(st, s-1, bl, il));
      else
        chk(!col_valid_o, {req, " col end"}, col_valid_o, 0);
      if (s - cl >= 0 && s - cl < bl)
        chk(rd_valid_o && rd_col_o == exp_col(st, s-cl, bl, il) && rd_bank_o == 2'(b),
            {req, " R7 rd"}, {rd_valid_o, 2'b0, rd_col_o}, exp_col(st, s-cl, bl, il));
      else
        chk(!rd_valid_o, {req, " R7 rd idle"}, rd_valid_o, 0);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] wm [4];
    logic [1:0] rm [4];
    wm = '{2'b00, 2'b10, 2'b01, 2'b11};
    rm = '{2'b00, 2'b01, 2'b10, 2'b00};
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 64; c++) mem[b][c] = '0;

    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state and default mode
    chk(!col_valid_o && !rd_valid_o && !wr_en_o && !mode_err_o, "R1 reset",
        {col_valid_o, rd_valid_o, wr_en_o, mode_err_o}, 0);
    run_read(1, 5, 1, 0, 2, "R1 default");

    // R2 / R3 reserved and unsupported words
    set_mode(7'h21, 0, "R2 valid load");
    set_mode(7'h24, 1, "R2 reserved length");
    run_read(0, 7, 2, 0, 2, "R2 mode kept");
    set_mode(7'h11, 1, "R2 reserved latency");
    set_mode(7'h2F, 1, "R3 interleave page");
    run_read(3, 9, 2, 0, 2, "R3 mode kept");
    set_mode(7'h2B, 0, "R2 interleave 8 ok");

    // R4 R5 R7 sweep over order, length, latency, low start bits
    for (int cl = 2; cl <= 3; cl++)
      for (int il = 0; il < 2; il++)
        for (int lg = 0; lg < 4; lg++) begin
          set_mode(7'(((cl == 3) ? 8'h30 : 8'h20) | (il << 3) | lg), 0, "R2 sweep load");
          for (int st = 0; st < 16; st++)
            run_read(st % 4, st + 32 * lg, 1 << lg, il[0], cl, il ? "R5 R12" : "R4 R12");
        end

    // R6 full page wrap, then R10 terminate
    set_mode(7'h27, 0, "R6 page load");
    step();
    drive(CMD_RD, 2, 508);
    for (int s = 1; s <= 520; s++) begin
      step();
      cmd_i = CMD_NOP;
      chk(col_valid_o && col_o == 9'((508 + s - 1) % 512) && bank_o == 2'd2,
          "R6 page col", col_o, (508 + s - 1) % 512);
    end
    cmd_i = CMD_TERM;
    step();
    cmd_i = CMD_NOP;
    chk(!col_valid_o, "R10 no beat after term", col_valid_o, 0);
    chk(rd_valid_o && rd_col_o == 9'd3, "R10 issued beat delivers", rd_col_o, 3);
    step();
    chk(!rd_valid_o && !col_valid_o, "R10 quiet", {rd_valid_o, col_valid_o}, 0);

    // R11 interrupt on an odd cycle, latency 3
    set_mode(7'h33, 0, "R11 load");
    step();
    drive(CMD_RD, 1, 16);
    for (int s = 1; s <= 14; s++) begin
      step();
      cmd_i = CMD_NOP;
      if (s <= 3)
        chk(col_valid_o && col_o == 9'(15 + s) && bank_o == 2'd1, "R11 old col", col_o, 15 + s);
      else if (s - 4 < 8)
        chk(col_valid_o && col_o == 9'(exp_col(37, s-4, 8, 0)) && bank_o == 2'd3,
            "R11 new col", col_o, exp_col(37, s-4, 8, 0));
      else
        chk(!col_valid_o, "R11 end", col_valid_o, 0);
      if (s >= 3 && s <= 5)
        chk(rd_valid_o && rd_col_o == 9'(13 + s) && rd_bank_o == 2'd1, "R11 R7 old rd",
            rd_col_o, 13 + s);
      else if (s >= 6 && s - 6 < 8)
        chk(rd_valid_o && rd_col_o == 9'(exp_col(37, s-6, 8, 0)) && rd_bank_o == 2'd3,
            "R11 R7 new rd", rd_col_o, exp_col(37, s-6, 8, 0));
      else
        chk(!rd_valid_o, "R11 rd idle", rd_valid_o, 0);
      if (s == 3) drive(CMD_RD, 3, 37);
    end

    // R13 mode load ends a write burst
    set_mode(7'h23, 0, "R13 load");
    step();
    drive(CMD_WR, 0, 0);
    step();
    cmd_i = CMD_NOP;
    chk(col_valid_o && wr_en_o, "R13 first beat", col_valid_o, 1);
    step();
    cmd_i  = CMD_LMR;
    mode_i = 7'h22;
    step();
    cmd_i = CMD_NOP;
    chk(!col_valid_o && !mode_err_o, "R13 stopped", {col_valid_o, mode_err_o}, 0);
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 64; c++) mem[b][c] = '0;

    // R8 masked write burst, length 4, latency 2
    step();
    drive(CMD_WR, 2, 65);
    dqm_i = wm[0];
    for (int k = 1; k <= 4; k++) begin
      step();
      cmd_i = CMD_NOP;
      dqm_i = (k < 4) ? wm[k] : 2'b00;
      chk(wr_en_o && !rd_valid_o && wr_be_o == ~wm[k-1] && col_o == 9'(exp_col(65, k-1, 4, 0))
          && bank_o == 2'd2, "R8 write beat", {wr_en_o, wr_be_o}, {1'b1, ~wm[k-1]});
    end
    step();
    chk(!wr_en_o, "R8 write end", wr_en_o, 0);

    // R9 read back with read-side masks
    step();
    drive(CMD_RD, 2, 65);
    dqm_i = rm[0];
    for (int s = 1; s <= 6; s++) begin
      step();
      cmd_i = CMD_NOP;
      dqm_i = (s < 4) ? rm[s] : 2'b00;
      if (s >= 2 && s <= 5) begin
        logic [15:0] got, want;
        int c;
        c = exp_col(65, s-2, 4, 0);
        got  = mem[rd_bank_o][rd_col_o[5:0]] & ~{{8{rd_mask_o[1]}}, {8{rd_mask_o[0]}}};
        want = wd(2, c) & {{8{~wm[s-2][1]}}, {8{~wm[s-2][0]}}}
                        & ~{{8{rm[s-2][1]}}, {8{rm[s-2][0]}}};
        chk(rd_valid_o && rd_mask_o == rm[s-2] && rd_col_o == 9'(c), "R9 mask align",
            {rd_valid_o, rd_mask_o}, {1'b1, rm[s-2]});
        chk(got == want, "R9 R8 data", got, want);
      end else begin
        chk(!rd_valid_o, "R9 rd idle", rd_valid_o, 0);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule